// File: doc/BRIEF.md
# Scrambled-Address Memory Decoder

This block sits between an 8-bit CPU and its memories on a board where the CPU address bus passes through an obfuscation stage that inverts the six least significant address lines. It decodes the bus into three chip selects: a 2 KB work RAM, a 4 KB background/video RAM that only ever takes writes through this path, and a two-byte protection register window. Before decoding it restores the true address by inverting those six lines once more.

The video side gets the restored address. The work RAM gets the bus address exactly as it arrives, with the low bits still inverted. Reads and writes go through the same permutation, so every work RAM location stays consistent. When a DMA engine holds the grant, the work RAM takes its 9-bit address, and the two address bits above it are forced high. The block also turns the active-low vertical blanking input into a single-cycle non-maskable interrupt pulse.

Every output is registered and changes one clock after the inputs that produce it.

Top module: `scram_addr_dec`

## Requirements
- R1: While rst_ni is low, every output is 0.
- R2: One clock after a CPU access (mreq_ni low and rd_ni or wr_ni low) whose true address (bus address XOR 0x003F) lies in 0x8800–0x8FFF, wram_cs_o is 1. True address 0x87FF does not select it.
- R3: One clock after a CPU write (mreq_ni and wr_ni low) to a true address in 0xC000–0xCFFF, bgram_cs_o is 1. A read of that range leaves it at 0.
- R4: One clock after a CPU read or write to true address 0xE000 or 0xE001, prot_cs_o is 1. True address 0xE002 does not select it.
- R5: With mreq_ni high, or with both rd_ni and wr_ni high, no select is asserted. At most one select is 1 in any cycle.
- R6: One clock after any input, vid_addr_o equals the low 12 bits of the true address, so bits 5:0 are the bus bits inverted and bits 11:6 are passed through.
- R7: Without a DMA grant, wram_addr_o is the bus address bits 10:0 taken one clock earlier, with no re-inversion.
- R8: While dma_gnt_i is high, one clock later wram_cs_o is 1, wram_addr_o is {2'b11, dma_addr_i}, and bgram_cs_o and prot_cs_o are 0 whatever the CPU drives.
- R9: nmi_o is a one-cycle pulse. It rises one clock after vblank_ni is first sampled low following a high sample. Holding vblank_ni low gives no further pulse, and vblank_ni sampled low in the first cycle after reset gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address as seen on the bus (low six bits inverted) |
| mreq_ni | input | 1 | Memory request, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| dma_addr_i | input | 9 | DMA work RAM address |
| dma_gnt_i | input | 1 | DMA owns the work RAM |
| vblank_ni | input | 1 | Vertical blanking, active low |
| wram_cs_o | output | 1 | Work RAM select |
| bgram_cs_o | output | 1 | Background/video RAM write select |
| prot_cs_o | output | 1 | Protection register window select |
| wram_addr_o | output | 11 | Work RAM address |
| vid_addr_o | output | 12 | Restored video/background RAM address |
| nmi_o | output | 1 | Non-maskable interrupt pulse |

## Verification
Each select, both address outputs and the interrupt are due exactly one rising edge after the inputs that produce them. No result needs more than that single register.

The driver applies one set of inputs on each falling edge and pushes the expected outputs for that set into a queue. The monitor takes one entry off the queue 1 ns after each rising edge and compares it, so every comparison happens in the first cycle the result is valid. For the interrupt, the driver keeps the last vblank level it drove and uses it to predict the pulse for the current cycle.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef struct packed {
    logic wram;
    logic bgram;
    logic prot;
  } cs_t;
endpackage

// File: rtl/sad_unscramble.sv
module sad_unscramble #(
  parameter int AW       = 16,
  parameter int INV_BITS = 6
) (
  input  logic [AW-1:0] bus_addr_i,
  output logic [AW-1:0] true_addr_o
);
  localparam logic [AW-1:0] INV_MASK = AW'((1 << INV_BITS) - 1);

  assign true_addr_o = bus_addr_i ^ INV_MASK;
endmodule

// File: rtl/sad_select.sv
module sad_select
  import sad_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            WRAM_AW   = 11,
  parameter int            BG_AW     = 12,
  parameter int            PROT_AW   = 1,
  parameter logic [AW-1:0] WRAM_BASE = 16'h8800,
  parameter logic [AW-1:0] BG_BASE   = 16'hC000,
  parameter logic [AW-1:0] PROT_BASE = 16'hE000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] true_addr_i,
  input  logic          mreq_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          dma_gnt_i,
  output cs_t           cs_o
);
  localparam int WRAM_TW = AW - WRAM_AW;
  localparam int BG_TW   = AW - BG_AW;
  localparam int PROT_TW = AW - PROT_AW;

  logic cpu_acc, cpu_wr;
  logic hit_wram, hit_bg, hit_prot;
  cs_t  cs_d;

  assign cpu_acc  = !mreq_ni && (!rd_ni || !wr_ni);
  assign cpu_wr   = !mreq_ni && !wr_ni;
  assign hit_wram = true_addr_i[AW-1:WRAM_AW] == WRAM_BASE[AW-1:WRAM_AW];
  assign hit_bg   = true_addr_i[AW-1:BG_AW]   == BG_BASE[AW-1:BG_AW];
  assign hit_prot = true_addr_i[AW-1:PROT_AW] == PROT_BASE[AW-1:PROT_AW];

  always_comb begin
    cs_d = '0;
    if (dma_gnt_i) begin
      cs_d.wram = 1'b1;  // DMA owns work RAM, CPU side muted
    end else begin
      cs_d.wram  = cpu_acc && hit_wram;
      cs_d.bgram = cpu_wr && hit_bg;
      cs_d.prot  = cpu_acc && hit_prot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_o <= '0;
    else         cs_o <= cs_d;
  end

  a_r5_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cs_o.wram, cs_o.bgram, cs_o.prot}));
  a_r5_cs_needs_mreq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o.bgram || cs_o.prot) |-> $past(!mreq_ni));
  a_r3_bg_write_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o.bgram |-> $past(!wr_ni));
endmodule

// File: rtl/sad_wram_mux.sv
module sad_wram_mux #(
  parameter int AW      = 16,
  parameter int WRAM_AW = 11,
  parameter int DMA_AW  = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      bus_addr_i,
  input  logic [DMA_AW-1:0]  dma_addr_i,
  input  logic               dma_gnt_i,
  output logic [WRAM_AW-1:0] wram_addr_o
);
  localparam int FILL_W = WRAM_AW - DMA_AW;

  logic [WRAM_AW-1:0] addr_d;

  // CPU path keeps the scrambled low bits; DMA path pads upper bits high
  assign addr_d = dma_gnt_i ? {{FILL_W{1'b1}}, dma_addr_i} : bus_addr_i[WRAM_AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wram_addr_o <= '0;
    else         wram_addr_o <= addr_d;
  end
endmodule

// File: rtl/sad_nmi_edge.sv
module sad_nmi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vblank_ni,
  output logic nmi_o
);
  logic vb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb_q  <= 1'b0;
      nmi_o <= 1'b0;
    end else begin
      vb_q  <= vblank_ni;
      nmi_o <= vb_q && !vblank_ni;
    end
  end

  a_r9_nmi_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |=> !nmi_o);
  a_r9_nmi_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> $past(!vblank_ni));
endmodule

// File: rtl/scram_addr_dec.sv
module scram_addr_dec
  import sad_pkg::*;
#(
  parameter int AW       = 16,
  parameter int INV_BITS = 6,
  parameter int WRAM_AW  = 11,
  parameter int DMA_AW   = 9,
  parameter int VID_AW   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic               mreq_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic [DMA_AW-1:0]  dma_addr_i,
  input  logic               dma_gnt_i,
  input  logic               vblank_ni,
  output logic               wram_cs_o,
  output logic               bgram_cs_o,
  output logic               prot_cs_o,
  output logic [WRAM_AW-1:0] wram_addr_o,
  output logic [VID_AW-1:0]  vid_addr_o,
  output logic               nmi_o
);
  logic [AW-1:0] true_addr;
  cs_t           cs;

  sad_unscramble #(.AW(AW), .INV_BITS(INV_BITS)) i_unscramble (
    .bus_addr_i  (addr_i),
    .true_addr_o (true_addr)
  );

  sad_select #(.AW(AW), .WRAM_AW(WRAM_AW), .BG_AW(VID_AW)) i_select (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .true_addr_i (true_addr),
    .mreq_ni     (mreq_ni),
    .rd_ni       (rd_ni),
    .wr_ni       (wr_ni),
    .dma_gnt_i   (dma_gnt_i),
    .cs_o        (cs)
  );

  sad_wram_mux #(.AW(AW), .WRAM_AW(WRAM_AW), .DMA_AW(DMA_AW)) i_wram_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (addr_i),
    .dma_addr_i  (dma_addr_i),
    .dma_gnt_i   (dma_gnt_i),
    .wram_addr_o (wram_addr_o)
  );

  sad_nmi_edge i_nmi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vblank_ni (vblank_ni),
    .nmi_o     (nmi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vid_addr_o <= '0;
    else         vid_addr_o <= true_addr[VID_AW-1:0];
  end

  assign wram_cs_o  = cs.wram;
  assign bgram_cs_o = cs.bgram;
  assign prot_cs_o  = cs.prot;

  a_r6_vid_low_restored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bgram_cs_o |-> vid_addr_o[INV_BITS-1:0] == ~$past(addr_i[INV_BITS-1:0]));
  a_r8_dma_fill_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wram_cs_o && $past(dma_gnt_i)) |-> &wram_addr_o[WRAM_AW-1:DMA_AW]);
endmodule

// File: tb/test_scram_addr_dec.sv
module test_scram_addr_dec;
  localparam time CLK_P = 5ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        mreq_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [8:0]  dma_addr_i = '0;
  logic        dma_gnt_i = 1'b0;
  logic        vblank_ni = 1'b1;
  logic        wram_cs_o, bgram_cs_o, prot_cs_o, nmi_o;
  logic [10:0] wram_addr_o;
  logic [11:0] vid_addr_o;

  always #(CLK_P/2) clk_i = ~clk_i;

  scram_addr_dec i_scram_addr_dec (
    .clk_i, .rst_ni, .addr_i, .mreq_ni, .rd_ni, .wr_ni, .dma_addr_i,
    .dma_gnt_i, .vblank_ni, .wram_cs_o, .bgram_cs_o, .prot_cs_o,
    .wram_addr_o, .vid_addr_o, .nmi_o
  );

  typedef struct {
    logic        wram, bg, prot, nmi;
    logic [10:0] wa;
    logic [11:0] va;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0, n_bad = 0;
  logic prev_vb = 1'b1;
  bit   done = 1'b0;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic [15:0] a, input logic mq, input logic rd, input logic wr,
                     input logic gnt, input logic [8:0] da, input logic vb, input string req);
    exp_t        e;
    logic [15:0] t;
    logic        acc;
    @(negedge clk_i);
    addr_i = a; mreq_ni = mq; rd_ni = rd; wr_ni = wr;
    dma_gnt_i = gnt; dma_addr_i = da; vblank_ni = vb;
    t   = a ^ 16'h003F;
    acc = !mq && (!rd || !wr);
    e.req = req;
    if (gnt) begin
      e.wram = 1'b1; e.bg = 1'b0; e.prot = 1'b0; e.wa = {2'b11, da};
    end else begin
      e.wram = acc && (t >= 16'h8800) && (t <= 16'h8FFF);
      e.bg   = !mq && !wr && (t[15:12] == 4'hC);
      e.prot = acc && (t == 16'hE000 || t == 16'hE001);
      e.wa   = a[10:0];
    end
    e.va  = t[11:0];
    e.nmi = prev_vb && !vb;
    prev_vb = vb;
    q.push_back(e);
  endtask

  // monitor: results are due one edge after the driven inputs
  always @(posedge clk_i) begin
    #1ns;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "wram_cs",   16'(wram_cs_o),   16'(e.wram));
      chk(e.req, "bgram_cs",  16'(bgram_cs_o),  16'(e.bg));
      chk(e.req, "prot_cs",   16'(prot_cs_o),   16'(e.prot));
      chk(e.req, "wram_addr", 16'(wram_addr_o), 16'(e.wa));
      chk(e.req, "vid_addr",  16'(vid_addr_o),  16'(e.va));
      chk(e.req, "nmi",       16'(nmi_o),       16'(e.nmi));
      chk(e.req, "onehot",    16'($countones({wram_cs_o, bgram_cs_o, prot_cs_o}) <= 1), 16'd1);
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    addr_i = 16'h883F; mreq_ni = 1'b0; rd_ni = 1'b0; vblank_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #1ns;
    // R1: reset holds outputs at zero despite active inputs
    chk("R1", "cs_all", 16'({wram_cs_o, bgram_cs_o, prot_cs_o, nmi_o}), 16'd0);
    chk("R1", "addrs",  16'(wram_addr_o | 11'(vid_addr_o)), 16'd0);
    @(negedge clk_i);
    mreq_ni = 1'b1; rd_ni = 1'b1;
    rst_ni = 1'b1;

    // R2 work RAM: bus values carry inverted low six bits
    drv(16'h8800 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R2");
    drv(16'h8FFF ^ 16'h003F, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1, "R2");
    drv(16'h87FF ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R2");
    drv(16'h8A55, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R7");
    // R3 background RAM: writes only
    drv(16'hC123 ^ 16'h003F, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1, "R3");
    drv(16'hC123 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R3");
    drv(16'hCFC0, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1, "R6");
    // R4 protection window
    drv(16'hE000 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R4");
    drv(16'hE001 ^ 16'h003F, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1, "R4");
    drv(16'hE002 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R4");
    // R5 no select without mreq or strobe
    drv(16'h8800 ^ 16'h003F, 1'b1, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R5");
    drv(16'hC000 ^ 16'h003F, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 1'b1, "R5");
    drv(16'hE000 ^ 16'h003F, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000, 1'b1, "R5");
    // R8 DMA owns work RAM, CPU write to bg ignored
    drv(16'hC000 ^ 16'h003F, 1'b0, 1'b1, 1'b0, 1'b1, 9'h155, 1'b1, "R8");
    drv(16'hE000 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b1, 9'h0AA, 1'b1, "R8");
    drv(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 9'h1FF, 1'b1, "R8");
    // R9 NMI: one pulse per falling edge, none while held low
    drv(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");
    drv(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");
    drv(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");
    drv(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b1, "R9");
    drv(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");
    drv(16'h8800 ^ 16'h003F, 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R9");
    // sweep of R6 and R7 over varied addresses
    for (int i = 0; i < 16; i++)
      drv(16'(i * 16'h1111 + 16'h0307), 1'b0, 1'b0, 1'b1, 1'b0, 9'h000, 1'b1, "R6");

    // R9 reset case: vblank low at first cycle after reset gives no pulse
    @(negedge clk_i);
    vblank_ni = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    prev_vb = 1'b0;
    drv(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");
    drv(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 1'b0, "R9");

    repeat (3) @(posedge clk_i);
    #2ns;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule